// File: doc/BRIEF.md
# Surge Indicator and Plot Inhibit

This block sits between a compressor surge detector and the nonvolatile surge map of a chiller controller. It takes a one-cycle surge-detected pulse and raises a surge indicator lamp for a fixed number of seconds, counted with a one-second tick. It also decides whether the detected surge may be written into the map. A write is refused while any of three conditions holds: the motor current limiter is active, the leaving-liquid temperature stability timer is running, or speed control is in manual mode. A second lamp shows that such a condition is present.

A service pushbutton, already debounced, can force a point into the map. Each press gives exactly one write strobe, whatever the inhibit conditions are. All outputs are registered. The write strobe is one clock wide, and the map storage takes it as its write enable.

Top module: `surge_plot_ctrl`

## Requirements
- R1: A high `surge_det_i` in a cycle sets `surge_lamp_o` high in the next cycle, whatever the inhibit flags are.
- R2: After the last surge pulse, `surge_lamp_o` stays high until the LAMP_SECS-th `sec_tick_i` that comes in a later cycle (default 2). It goes low in the cycle after that tick. A tick in the same cycle as a surge pulse is not counted.
- R3: A surge pulse while the surge lamp is on restarts the full LAMP_SECS countdown.
- R4: `inhibit_lamp_o` in a cycle equals the OR of `curr_limit_i`, `temp_unstable_i` and `manual_speed_i` in the previous cycle.
- R5: A surge pulse in a cycle where all three inhibit flags are low gives `plot_wr_o` high for one cycle in the next cycle. A surge pulse while any flag is high gives no strobe.
- R6: A rising edge of `insert_btn_i` (high now, low in the previous cycle) gives `plot_wr_o` high in the next cycle, whatever the inhibit flags are. Holding the button or releasing it gives no further strobe.
- R7: A permitted surge and a button rising edge in the same cycle give one single-cycle strobe, not two.
- R8: While `rst` is high and in the first cycle after it falls, both lamps and `plot_wr_o` are low. The button history is cleared to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| surge_det_i | input | 1 | One-cycle pulse per detected surge |
| insert_btn_i | input | 1 | Debounced manual insert pushbutton level |
| curr_limit_i | input | 1 | Motor current limit active |
| temp_unstable_i | input | 1 | Temperature stability timer running |
| manual_speed_i | input | 1 | Speed control in manual mode |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| surge_lamp_o | output | 1 | Timed surge indicator |
| inhibit_lamp_o | output | 1 | Map recording inhibited indicator |
| plot_wr_o | output | 1 | One-cycle map write strobe |

## Verification
Two pairs of functions can fall in the same cycle. A permitted surge can meet a button rising edge, and both compete for the one write strobe. A surge pulse can also meet a seconds tick, and both act on the lamp countdown. The bench walks every pair of consecutive input patterns over all six inputs, which creates both collisions many times. A cycle-level model built from the requirements then expects exactly one strobe for the merged writes, and a reload that ignores the coincident tick.

// File: rtl/sip_pkg.sv
package sip_pkg;
  localparam int unsigned N_INHIBIT = 3;
  localparam int unsigned IDX_CURR = 0;
  localparam int unsigned IDX_UNSTABLE = 1;
  localparam int unsigned IDX_MANUAL = 2;

  typedef logic [N_INHIBIT-1:0] inhibit_vec_t;

  function automatic logic any_inhibit(input inhibit_vec_t v);
    return |v;
  endfunction
endpackage

// File: rtl/sip_inhibit_gate.sv
module sip_inhibit_gate
  import sip_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  inhibit_vec_t cond_i,
  output logic         inhibit_o,
  output logic         inhibit_lamp_o
);
  assign inhibit_o = any_inhibit(cond_i);

  always_ff @(posedge clk) begin
    if (rst) inhibit_lamp_o <= 1'b0;
    else     inhibit_lamp_o <= inhibit_o;
  end
endmodule

// File: rtl/sip_lamp_timer.sv
module sip_lamp_timer #(
  parameter int unsigned LAMP_SECS = 2,
  localparam int unsigned CW = $clog2(LAMP_SECS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic tick_i,
  output logic lamp_o
);
  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      lamp_o   <= 1'b0;
    end else if (trig_i) begin
      remain_q <= CW'(LAMP_SECS);
      lamp_o   <= 1'b1;
    end else if (tick_i && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
      if (remain_q == CW'(1)) lamp_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sip_rise_detect.sv
module sip_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/sip_plot_strobe.sv
module sip_plot_strobe (
  input  logic clk,
  input  logic rst,
  input  logic surge_i,
  input  logic inhibit_i,
  input  logic insert_i,
  output logic wr_o
);
  logic want_wr;
  assign want_wr = (surge_i & ~inhibit_i) | insert_i;

  always_ff @(posedge clk) begin
    if (rst) wr_o <= 1'b0;
    else     wr_o <= want_wr;
  end
endmodule

// File: rtl/surge_plot_ctrl.sv
module surge_plot_ctrl
  import sip_pkg::*;
#(
  parameter int unsigned LAMP_SECS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic surge_det_i,
  input  logic insert_btn_i,
  input  logic curr_limit_i,
  input  logic temp_unstable_i,
  input  logic manual_speed_i,
  input  logic sec_tick_i,
  output logic surge_lamp_o,
  output logic inhibit_lamp_o,
  output logic plot_wr_o
);
  inhibit_vec_t cond;
  logic         inhibit;
  logic         insert_rise;

  always_comb begin
    cond               = '0;
    cond[IDX_CURR]     = curr_limit_i;
    cond[IDX_UNSTABLE] = temp_unstable_i;
    cond[IDX_MANUAL]   = manual_speed_i;
  end

  sip_inhibit_gate u_gate (
    .clk            (clk),
    .rst            (rst),
    .cond_i         (cond),
    .inhibit_o      (inhibit),
    .inhibit_lamp_o (inhibit_lamp_o)
  );

  sip_lamp_timer #(.LAMP_SECS(LAMP_SECS)) u_lamp (
    .clk    (clk),
    .rst    (rst),
    .trig_i (surge_det_i),
    .tick_i (sec_tick_i),
    .lamp_o (surge_lamp_o)
  );

  sip_rise_detect u_btn (
    .clk     (clk),
    .rst     (rst),
    .level_i (insert_btn_i),
    .rise_o  (insert_rise)
  );

  sip_plot_strobe u_wr (
    .clk       (clk),
    .rst       (rst),
    .surge_i   (surge_det_i),
    .inhibit_i (inhibit),
    .insert_i  (insert_rise),
    .wr_o      (plot_wr_o)
  );
endmodule

// File: rtl/surge_plot_ctrl_chk.sv
module surge_plot_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic surge_det_i,
  input logic insert_btn_i,
  input logic curr_limit_i,
  input logic temp_unstable_i,
  input logic manual_speed_i,
  input logic sec_tick_i,
  input logic surge_lamp_o,
  input logic inhibit_lamp_o,
  input logic plot_wr_o
);
  logic btn_seen_q;
  logic any_flag;

  always_ff @(posedge clk) begin
    if (rst) btn_seen_q <= 1'b0;
    else     btn_seen_q <= insert_btn_i;
  end

  assign any_flag = curr_limit_i | temp_unstable_i | manual_speed_i;

  AST_SURGE_LIGHTS: assert property (@(posedge clk) disable iff (rst)
    surge_det_i |=> surge_lamp_o); // R1
  AST_LAMP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (surge_lamp_o && !sec_tick_i) |=> surge_lamp_o); // R2
  AST_LAMP_DARK_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!surge_lamp_o && !surge_det_i) |=> !surge_lamp_o); // R2
  AST_INHIBIT_ON: assert property (@(posedge clk) disable iff (rst)
    any_flag |=> inhibit_lamp_o); // R4
  AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (rst)
    !any_flag |=> !inhibit_lamp_o); // R4
  AST_CLEAN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (surge_det_i && !any_flag) |=> plot_wr_o); // R5
  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (surge_det_i && any_flag && !(insert_btn_i && !btn_seen_q)) |=> !plot_wr_o); // R5
  AST_INSERT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (insert_btn_i && !btn_seen_q) |=> plot_wr_o); // R6
  AST_NO_HELD_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!surge_det_i && !(insert_btn_i && !btn_seen_q)) |=> !plot_wr_o); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!surge_lamp_o && !inhibit_lamp_o && !plot_wr_o)); // R8
endmodule

bind surge_plot_ctrl surge_plot_ctrl_chk chk_i (
  .clk             (clk),
  .rst             (rst),
  .surge_det_i     (surge_det_i),
  .insert_btn_i    (insert_btn_i),
  .curr_limit_i    (curr_limit_i),
  .temp_unstable_i (temp_unstable_i),
  .manual_speed_i  (manual_speed_i),
  .sec_tick_i      (sec_tick_i),
  .surge_lamp_o    (surge_lamp_o),
  .inhibit_lamp_o  (inhibit_lamp_o),
  .plot_wr_o       (plot_wr_o)
);

// File: tb/surge_plot_ctrl_tb_top.sv
module surge_plot_ctrl_tb_top;
  localparam int unsigned LAMP_SECS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic surge_det_i = 1'b0;
  logic insert_btn_i = 1'b0;
  logic curr_limit_i = 1'b0;
  logic temp_unstable_i = 1'b0;
  logic manual_speed_i = 1'b0;
  logic sec_tick_i = 1'b0;
  logic surge_lamp_o;
  logic inhibit_lamp_o;
  logic plot_wr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench-side model state
  int  m_cnt = 0;
  bit  m_lamp = 1'b0;
  bit  m_inh = 1'b0;
  bit  m_wr = 1'b0;
  bit  m_btn_prev = 1'b0;

  always #5 clk = ~clk;

  surge_plot_ctrl #(.LAMP_SECS(LAMP_SECS)) dut_i (
    .clk             (clk),
    .rst             (rst),
    .surge_det_i     (surge_det_i),
    .insert_btn_i    (insert_btn_i),
    .curr_limit_i    (curr_limit_i),
    .temp_unstable_i (temp_unstable_i),
    .manual_speed_i  (manual_speed_i),
    .sec_tick_i      (sec_tick_i),
    .surge_lamp_o    (surge_lamp_o),
    .inhibit_lamp_o  (inhibit_lamp_o),
    .plot_wr_o       (plot_wr_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // pattern bits: 0 surge, 1 button, 2 current limit, 3 unstable, 4 manual, 5 tick
  task automatic step(input logic [5:0] p);
    bit flag;
    bit rise;
    surge_det_i     = p[0];
    insert_btn_i    = p[1];
    curr_limit_i    = p[2];
    temp_unstable_i = p[3];
    manual_speed_i  = p[4];
    sec_tick_i      = p[5];
    flag = p[2] | p[3] | p[4];
    rise = p[1] & ~m_btn_prev;
    m_btn_prev = p[1];
    m_inh = flag;
    m_wr  = (p[0] & ~flag) | rise;
    if (p[0]) begin
      m_cnt  = LAMP_SECS;
      m_lamp = 1'b1;
    end else if (p[5] && m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) m_lamp = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check("R1 R2 R3 surge lamp", surge_lamp_o, m_lamp);
    check("R4 inhibit lamp", inhibit_lamp_o, m_inh);
    check("R5 R6 R7 plot strobe", plot_wr_o, m_wr);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    // R8: reset state held with busy inputs
    surge_det_i = 1'b1;
    insert_btn_i = 1'b1;
    curr_limit_i = 1'b1;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      check("R8 reset surge lamp", surge_lamp_o, 1'b0);
      check("R8 reset inhibit lamp", inhibit_lamp_o, 1'b0);
      check("R8 reset strobe", plot_wr_o, 1'b0);
    end
    surge_det_i = 1'b0;
    insert_btn_i = 1'b0;
    curr_limit_i = 1'b0;
    rst = 1'b0;
    step(6'd0); // R8 first cycle after reset, all quiet

    // R2 R3 directed: restart mid countdown
    step(6'b000001);
    step(6'b100000);
    step(6'b000001);
    step(6'b100000);
    step(6'b000000);
    step(6'b100000);
    check("R3 lamp off after restart count", surge_lamp_o, 1'b0);
    // R6: held button gives only one strobe
    step(6'b010010);
    step(6'b010010);
    check("R6 held button no second strobe", plot_wr_o, 1'b0);
    step(6'b000000);
    // R7: coincident permitted surge and press
    step(6'b000011);
    step(6'b000000);
    check("R7 single strobe after merge", plot_wr_o, 1'b0);

    // exhaustive sweep of all consecutive pattern pairs
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        step(6'(a));
        step(6'(b));
      end
    end

    // pseudo-random runs with sparse ticks and surges
    lfsr = 16'hACE1;
    for (int k = 0; k < 6000; k++) begin
      logic [5:0] p;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p = lfsr[5:0];
      p[0] = p[0] & lfsr[9] & lfsr[11];
      p[5] = p[5] & lfsr[7];
      step(p);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule